// File: doc/BRIEF.md
# Display Event Interrupt Register

This block gathers four display-timing events into one 32-bit control and status word and drives a single level interrupt line. The four sources are: a frame that has finished, a display update that has finished, a programmed frame count being reached, and a programmed line being scanned. Each source has a sticky status flag, an enable bit and a write-one-to-clear bit, and all of them sit in the same word. The frame count and line number that trigger the last two sources are also held in the block.

Software, or a bus adapter in front of the block, reads and writes the word through a plain port. `reg_sel_i` chooses between the interrupt word (0) and the line-number word (1). The write takes effect on the next clock edge. The read data is combinational from the stored state. The display timing logic supplies single-cycle event pulses, and it supplies the index of the current line together with a strobe.

Top module: `disp_evt_irq_reg`

## Requirements
- R1: After reset every status flag, enable, frame number and line number is 0, `irq_o` is low, and both words read as 0.
- R2: A pulse on `frame_end_i` sets status bit 0, and a pulse on `disp_end_i` sets status bit 1. Each flag appears on the clock edge that samples the pulse and stays set until it is cleared.
- R3: Bits 7:4 of the interrupt word are read/write enables for sources 0..3 (1 = enabled). `irq_o` is high exactly when some status bit and its enable are both 1.
- R4: Writing 1 to bit 8+i of the interrupt word clears status bit i. Writing 0 there leaves the flag unchanged. Bits 11:8 always read as 0, and writes to status bits 3:0 are ignored.
- R5: If an event for a source arrives in the same cycle as a write that clears it, the status flag ends up set.
- R6: Bits 19:12 hold an 8-bit frame number N. A pulse on `frame_start_i` resets the count of completed frames to 0, and each `frame_end_i` adds one to it. Status bit 2 is set by the frame end that arrives while N frames have already completed, so it is raised by frame end number N+1, counted from 1.
- R7: The completed-frame count saturates beyond the 8-bit range. Once bit 2 has fired, further frame ends do not raise it again until the next `frame_start_i`.
- R8: Word 1 holds the line number in bits 10:0 (read/write). A `line_stb_i` whose `line_idx_i` equals it sets status bit 3. A strobe on any other index does not set bit 3.
- R9: Bits 31:20 of word 0 and bits 31:11 of word 1 read as 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel_i | input | 1 | Word select: 0 interrupt word, 1 line-number word |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| frame_start_i | input | 1 | Start of a frame sequence, resets the frame count |
| frame_end_i | input | 1 | One frame finished |
| disp_end_i | input | 1 | Display update finished |
| line_stb_i | input | 1 | A line index is presented |
| line_idx_i | input | 11 | Index of the current line |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions take the event inputs to be synchronous single-cycle samples. They also rely on the frame count being brought back to zero only by `frame_start_i` and on nothing else. The stimulus drives every input half a cycle away from the sampling edge and runs long frame sequences that push the count to saturation. It also lines events up with clears in the same cycle, and it puts a frame start and a frame end in the same cycle, so that the priority cases the assertions describe are reached.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
   localparam int NUM_SRC  = 4;
   localparam int ST_LSB   = 0;
   localparam int EN_LSB   = ST_LSB + NUM_SRC;
   localparam int CLR_LSB  = EN_LSB + NUM_SRC;
   localparam int FNUM_LSB = CLR_LSB + NUM_SRC;

   typedef enum int {
      SRC_FRM_END = 0,
      SRC_DSP_END = 1,
      SRC_FRM_CNT = 2,
      SRC_LINE    = 3
   } src_e;

   typedef enum logic {
      SEL_IRQ_WORD  = 1'b0,
      SEL_LINE_WORD = 1'b1
   } sel_e;
endpackage

// File: rtl/disp_sticky_bit.sv
module disp_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic st_o
);
   logic st_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        st_q <= 1'b0;
      else if (evt_i)    st_q <= 1'b1;
      else if (clr_i)    st_q <= 1'b0;
   end

   assign st_o = st_q;

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> st_o) else $error("event lost");                    // R5
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> !st_o) else $error("clear ignored");     // R4
   AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i && !clr_i) |=> $stable(st_o)) else $error("flag moved"); // R2
endmodule

// File: rtl/disp_frm_cmp.sv
module disp_frm_cmp #(
   parameter int NUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             end_i,
   input  logic [NUM_W-1:0] num_i,
   output logic             hit_o
);
   localparam int CNT_W = NUM_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {NUM_W{1'b0}}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (start_i)                   cnt_q <= '0;
      else if (end_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign hit_o = end_i && !start_i && (cnt_q == {1'b0, num_i});

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> cnt_q == '0) else $error("count not restarted");   // R6
   AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !start_i) |=> cnt_q == CNT_MAX)
      else $error("count left saturation");                          // R7
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !end_i) |=> $stable(cnt_q)) else $error("count drift"); // R6
endmodule

// File: rtl/disp_line_cmp.sv
module disp_line_cmp #(
   parameter int LINE_W = 11
) (
   input  logic              stb_i,
   input  logic [LINE_W-1:0] idx_i,
   input  logic [LINE_W-1:0] num_i,
   output logic              hit_o
);
   assign hit_o = stb_i && (idx_i == num_i);
endmodule

// File: rtl/disp_evt_irq_reg.sv
module disp_evt_irq_reg
   import disp_irq_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int FRM_W   = 8,
   parameter int LINE_W  = 11,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              frame_start_i,
   input  logic              frame_end_i,
   input  logic              disp_end_i,
   input  logic              line_stb_i,
   input  logic [LINE_W-1:0] line_idx_i,
   output logic              irq_o
);
   localparam int FNUM_MSB = FNUM_LSB + FRM_W - 1;

   if (DATA_W < FNUM_MSB + 1) begin : g_bad_frm_w
      $error("interrupt word too narrow for frame number field");
   end
   if (DATA_W < LINE_W) begin : g_bad_line_w
      $error("line number wider than data word");
   end

   logic [NUM_SRC-1:0] en_q;
   logic [FRM_W-1:0]   fnum_q;
   logic [LINE_W-1:0]  lnum_q;
   logic [NUM_SRC-1:0] evt;
   logic [NUM_SRC-1:0] clr;
   logic [NUM_SRC-1:0] st;
   logic               wr_irq, wr_line;
   logic               frm_hit, line_hit;
   logic               irq_raw;

   assign wr_irq  = reg_wr_i && (reg_sel_i == SEL_IRQ_WORD);
   assign wr_line = reg_wr_i && (reg_sel_i == SEL_LINE_WORD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         fnum_q <= '0;
         lnum_q <= '0;
      end else begin
         if (wr_irq) begin
            en_q   <= reg_wdata_i[EN_LSB +: NUM_SRC];
            fnum_q <= reg_wdata_i[FNUM_LSB +: FRM_W];
         end
         if (wr_line) lnum_q <= reg_wdata_i[LINE_W-1:0];
      end
   end

   disp_frm_cmp #(.NUM_W(FRM_W)) u_frm_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (frame_start_i),
      .end_i   (frame_end_i),
      .num_i   (fnum_q),
      .hit_o   (frm_hit)
   );

   disp_line_cmp #(.LINE_W(LINE_W)) u_line_cmp (
      .stb_i (line_stb_i),
      .idx_i (line_idx_i),
      .num_i (lnum_q),
      .hit_o (line_hit)
   );

   assign evt[SRC_FRM_END] = frame_end_i;
   assign evt[SRC_DSP_END] = disp_end_i;
   assign evt[SRC_FRM_CNT] = frm_hit;
   assign evt[SRC_LINE]    = line_hit;
   assign clr = wr_irq ? reg_wdata_i[CLR_LSB +: NUM_SRC] : '0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      disp_sticky_bit u_st (
         .clk   (clk),
         .rst_n (rst_n),
         .evt_i (evt[i]),
         .clr_i (clr[i]),
         .st_o  (st[i])
      );
   end

   assign irq_raw = |(st & en_q);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end

   always_comb begin
      reg_rdata_o = '0;
      if (reg_sel_i == SEL_IRQ_WORD) begin
         reg_rdata_o[ST_LSB +: NUM_SRC]  = st;
         reg_rdata_o[EN_LSB +: NUM_SRC]  = en_q;
         reg_rdata_o[FNUM_LSB +: FRM_W]  = fnum_q;
      end else begin
         reg_rdata_o[LINE_W-1:0] = lnum_q;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata_i[DATA_W-1:FNUM_MSB+1], reg_wdata_i[ST_LSB +: NUM_SRC]};

   AST_FNUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_irq |=> $stable(fnum_q)) else $error("frame number moved");  // R6
   AST_LNUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_line |=> $stable(lnum_q)) else $error("line number moved"); // R8
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_irq |=> $stable(en_q)) else $error("enables moved");        // R3
endmodule

// File: tb/disp_evt_irq_reg_tb.sv
module disp_evt_irq_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel_i = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        frame_start_i = 1'b0;
   logic        frame_end_i = 1'b0;
   logic        disp_end_i = 1'b0;
   logic        line_stb_i = 1'b0;
   logic [10:0] line_idx_i = '0;
   logic        irq_o;

   always #5 clk = ~clk;

   disp_evt_irq_reg u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .frame_start_i(frame_start_i), .frame_end_i(frame_end_i),
      .disp_end_i(disp_end_i), .line_stb_i(line_stb_i),
      .line_idx_i(line_idx_i), .irq_o(irq_o)
   );

   int n_chk = 0, n_fail = 0, cycles = 0;
   string cur_req = "R1";
   bit done = 0;

   // reference model state
   bit [3:0] m_st, m_en;
   int m_fnum, m_lnum, m_cnt;

   always @(posedge clk) begin
      bit [3:0] ev, cl;
      if (!rst_n) begin
         m_st = 0; m_en = 0; m_fnum = 0; m_lnum = 0; m_cnt = 0;
      end else begin
         ev[0] = frame_end_i;
         ev[1] = disp_end_i;
         ev[2] = frame_end_i && !frame_start_i && (m_cnt == m_fnum);
         ev[3] = line_stb_i && (int'(line_idx_i) == m_lnum);
         cl = (reg_wr_i && !reg_sel_i) ? reg_wdata_i[11:8] : 4'd0;
         for (int i = 0; i < 4; i++) begin
            if (ev[i]) m_st[i] = 1'b1;
            else if (cl[i]) m_st[i] = 1'b0;
         end
         if (reg_wr_i && !reg_sel_i) begin
            m_en = reg_wdata_i[7:4];
            m_fnum = int'(reg_wdata_i[19:12]);
         end
         if (reg_wr_i && reg_sel_i) m_lnum = int'(reg_wdata_i[10:0]);
         if (frame_start_i) m_cnt = 0;
         else if (frame_end_i && m_cnt < 256) m_cnt = m_cnt + 1;
      end
   end

   function automatic bit [31:0] exp_rdata();
      bit [31:0] r = '0;
      if (!reg_sel_i) begin
         r[3:0] = m_st; r[7:4] = m_en; r[19:12] = m_fnum[7:0];
      end else r[10:0] = m_lnum[10:0];
      return r;
   endfunction

   task automatic chk(string req, string what, bit [31:0] act, bit [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // compare every clock, away from the sampling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "rdata", reg_rdata_o, exp_rdata());
         chk("R3", "irq", {31'd0, irq_o}, {31'd0, |(m_st & m_en)});
      end
      cycles++;
      if (cycles > 100000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic step(bit sel = 0, bit wr = 0, bit [31:0] wd = 0,
                       bit fs = 0, bit fe = 0, bit de = 0,
                       bit ls = 0, int li = 0);
      @(negedge clk); #1;
      reg_sel_i = sel; reg_wr_i = wr; reg_wdata_i = wd;
      frame_start_i = fs; frame_end_i = fe; disp_end_i = de;
      line_stb_i = ls; line_idx_i = li[10:0];
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #2;
      chk("R1", "reset word0", reg_rdata_o, 32'h0);
      chk("R1", "reset irq", {31'd0, irq_o}, 32'h0);
      reg_sel_i = 1; #1;
      chk("R1", "reset word1", reg_rdata_o, 32'h0);
      reg_sel_i = 0;

      // frame number 5 so source 2 stays quiet here
      cur_req = "R2";
      step(0, 1, 32'h0000_5000);
      step(0, 0, 0, 0, 1);
      idle(2);
      step(0, 0, 0, 0, 0, 1);
      idle(2);
      #2 chk("R2", "flags 0 and 1 sticky", {28'd0, reg_rdata_o[3:0]}, 32'h3);

      cur_req = "R3";
      step(0, 1, 32'h0000_5020);   // enable display end only
      idle(1);
      #2 chk("R3", "irq on enabled flag", {31'd0, irq_o}, 32'h1);
      step(0, 1, 32'h0000_5080);   // enable only line flag
      idle(1);
      #2 chk("R3", "irq off when masked", {31'd0, irq_o}, 32'h0);

      cur_req = "R4";
      step(0, 1, 32'h0000_50FF);   // write status bits, clear none
      idle(1);
      #2 chk("R4", "status writes ignored", {28'd0, reg_rdata_o[3:0]}, 32'h3);
      step(0, 1, 32'h0000_51F0);   // clear bit 0 only
      idle(1);
      #2 chk("R4", "single clear", {28'd0, reg_rdata_o[3:0]}, 32'h2);
      chk("R4", "clear bits read 0", {28'd0, reg_rdata_o[11:8]}, 32'h0);

      cur_req = "R5";
      step(0, 1, 32'h0000_53F0, 0, 0, 1);  // clear bit1 with display end
      idle(1);
      #2 chk("R5", "event beats clear", {28'd0, reg_rdata_o[3:0]}, 32'h2);
      step(0, 1, 32'h0000_5FF0);
      idle(1);

      cur_req = "R6";
      step(0, 1, 32'h0000_3040);   // N=3, enable frame-count source
      step(0, 0, 0, 1);            // frame start
      for (int f = 0; f < 3; f++) begin step(0, 0, 0, 0, 1); idle(2); end
      #2 chk("R6", "not yet", {31'd0, reg_rdata_o[2]}, 32'h0);
      step(0, 0, 0, 0, 1);
      idle(1);
      #2 chk("R6", "fired on frame 4", {31'd0, reg_rdata_o[2]}, 32'h1);
      step(0, 1, 32'h0000_3440);
      step(0, 0, 0, 1, 1);         // start and end together
      for (int f = 0; f < 4; f++) begin step(0, 0, 0, 0, 1); idle(1); end
      #2 chk("R6", "start with end restarts count", {31'd0, reg_rdata_o[2]}, 32'h1);

      cur_req = "R7";
      step(0, 1, 32'h0000_3440);
      for (int f = 0; f < 300; f++) step(0, 0, 0, 0, 1);
      idle(1);
      #2 chk("R7", "no refire after saturation", {31'd0, reg_rdata_o[2]}, 32'h0);
      step(0, 1, 32'h000F_F440);   // N=255
      step(0, 0, 0, 1);
      for (int f = 0; f < 256; f++) step(0, 0, 0, 0, 1);
      idle(1);
      #2 chk("R7", "top frame number fires", {31'd0, reg_rdata_o[2]}, 32'h1);
      step(0, 1, 32'h000F_F440);
      for (int f = 0; f < 20; f++) step(0, 0, 0, 0, 1);
      idle(1);
      #2 chk("R7", "top number not repeated", {31'd0, reg_rdata_o[2]}, 32'h0);

      cur_req = "R8";
      step(1, 1, 32'd600);
      step(1, 0, 0, 0, 0, 0, 1, 599);
      step(1, 0, 0, 0, 0, 0, 1, 601);
      step(0);
      #2 chk("R8", "other lines ignored", {31'd0, reg_rdata_o[3]}, 32'h0);
      step(1, 0, 0, 0, 0, 0, 1, 600);
      step(0);
      #2 chk("R8", "matching line flags", {31'd0, reg_rdata_o[3]}, 32'h1);
      step(1, 1, 32'd2047);
      step(1, 0, 0, 0, 0, 0, 1, 2047);
      idle(2);

      cur_req = "R9";
      step(0, 1, 32'hFFFF_FFFF);
      step(1, 1, 32'hFFFF_F800);
      step(0);
      #2 chk("R9", "word0 reserved zero", {12'd0, 20'd0} | (reg_rdata_o & 32'hFFF0_0F00), 32'h0);
      step(1);
      #2 chk("R9", "word1 reserved zero", reg_rdata_o, 32'h0);
      idle(3);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule